// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects six interrupt requests for a small CPU and decides which of them is served first. Three requests come from single-cycle time-out pulses of three timers. The other three come from edge detectors on two input pins. Each detector first synchronises its pin and then filters out short glitches. Every request event sets a pending bit. The pending bits are gated by a per-source enable and by a master enable, and the lowest-numbered active source wins. The controller drives an interrupt line and the vector address of the winning source.

The CPU takes an interrupt with an acknowledge strobe. This clears the pending bit of the presented source and drops the master enable, so the service routine is not interrupted again. A return strobe turns the master enable back on. Separate enable and disable strobes set and clear the master enable outside of service. A single-register write/read port holds the six enables and the master enable.

Top module: `prio_vic`

## Requirements
- R1: After reset the mask register reads 00h, `irq` is 0 and `vec` is 0. Both filtered pin levels start high.
- R2: A write with `wr_en` loads `wr_data[5:0]` into the six source enables and `wr_data[7]` into the master enable. `rd_data` returns {master, 0, enables[5:0]}. Bit 6 always reads 0 and ignores writes.
- R3: A pulse on `tmr_tick[0]`, `tmr_tick[1]` or `tmr_tick[2]` sets the pending bit of source 0, 2 or 5. The bit is set whatever the enable and master state, and it stays set until that source is acknowledged.
- R4: A falling edge on `pin_a` raises source 1 and a rising edge on `pin_a` raises source 4. A falling edge on `pin_b` raises source 3. A rising edge on `pin_b` raises nothing.
- R5: Each pin passes through a two-flop synchronizer. A new level is accepted, and its edge taken, only after it has been seen on N_MIN consecutive clocks (default 2). With the default, a pin pulse of one clock period is ignored.
- R6: `irq` is 1 exactly when the master enable is 1 and at least one pending source is also enabled.
- R7: Among the active sources, the lowest index n wins, and `vec` shows 2*n+2 (2, 4, 6, 8, 10, 12 for sources 0 to 5). While `irq` is 0, `vec` is 0.
- R8: `ack` while `irq` is 1 clears only the pending bit of the presented source, and it clears the master enable. `ack` while `irq` is 0 has no effect.
- R9: `ei` and `reti` set the master enable, and `di` clears it. An effective `ack` wins over `di`, `di` wins over `ei`/`reti`, and any strobe wins over the bit 7 value of a write in the same cycle.
- R10: A request event in the same cycle as an acknowledge of a different source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 3 | Timer time-out pulses (bit k from timer k) |
| pin_a | input | 1 | Asynchronous pin, both edges used |
| pin_b | input | 1 | Asynchronous pin, falling edge used |
| ei | input | 1 | Master enable set strobe |
| di | input | 1 | Master enable clear strobe |
| ack | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| wr_en | input | 1 | Mask register write strobe |
| wr_data | input | 8 | Mask register write data |
| rd_data | output | 8 | Mask register read value |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 8 | Vector low-byte address of the winner |

## Verification
A table of mask values and timer-tick patterns shows that the lowest enabled pending index wins. It also shows that a disabled source is skipped and that a cleared master enable hides every pending bit. Pin edges are driven separately on each pin and in each direction. This separates the three edge-to-source mappings and shows that a rising edge on `pin_b` raises nothing. One-clock and two-clock pin pulses tell a rejected glitch from an accepted edge. Several sources pending together, acknowledge collisions with new events, and simultaneous strobes show that acknowledge clears only the presented source and follows the stated precedence.

// File: rtl/prio_vic.sv
module prio_vic #(
  parameter int N_MIN = 2,
  parameter int VW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    tmr_tick,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          ei,
  input  logic          di,
  input  logic          ack,
  input  logic          reti,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          irq,
  output logic [VW-1:0] vec
);
  localparam int NS = 6;
  localparam int NP = 2;
  localparam int CW = (N_MIN > 1) ? $clog2(N_MIN) : 1;

  logic [NP-1:0] pin_v, lvl, take;
  logic [NS-1:0] en, pend, act, ev, clr;
  logic          me, me_n;
  logic [2:0]    win;
  logic          unused_wd6;

  assign pin_v      = {pin_b, pin_a};
  assign unused_wd6 = wr_data[6];

  for (genvar g = 0; g < NP; g++) begin : g_pin
    logic [1:0]    sy;
    logic          acc;
    logic [CW-1:0] cnt;

    assign lvl[g]  = sy[1];
    assign take[g] = (sy[1] != acc) && (cnt == CW'(N_MIN - 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy  <= 2'b11;
        acc <= 1'b1;
        cnt <= '0;
      end else begin
        sy <= {sy[0], pin_v[g]};
        if (sy[1] == acc) begin
          cnt <= '0;
        end else if (take[g]) begin
          acc <= sy[1];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ev = {tmr_tick[2],
               take[0] &  lvl[0],
               take[1] & ~lvl[1],
               tmr_tick[1],
               take[0] & ~lvl[0],
               tmr_tick[0]};

  assign act = pend & en & {NS{me}};
  assign irq = |act;

  always_comb begin
    win = 3'd0;
    for (int i = NS - 1; i >= 0; i--)
      if (act[i]) win = 3'(i);
  end

  assign vec = irq ? VW'(2 * int'(win) + 2) : '0;
  assign clr = (ack && irq) ? (NS'(1) << win) : '0;

  always_comb begin
    me_n = wr_en ? wr_data[7] : me;
    if (ei || reti) me_n = 1'b1;
    if (di)         me_n = 1'b0;
    if (ack && irq) me_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      me   <= 1'b0;
      pend <= '0;
    end else begin
      if (wr_en) en <= wr_data[5:0];
      me   <= me_n;
      pend <= (pend & ~clr) | ev;
    end
  end

  assign rd_data = {me, 1'b0, en};
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    tmr_tick,
  input logic          ei,
  input logic          di,
  input logic          ack,
  input logic          reti,
  input logic          wr_en,
  input logic [7:0]    rd_data,
  input logic          irq,
  input logic [VW-1:0] vec
);
  a_r6_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[7]);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[5:0] != 6'd0));

  a_r7_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec >= VW'(2) && vec <= VW'(12) && !vec[0]));

  a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec == '0));

  a_r2_bit6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == 1'b0);

  a_r8_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !rd_data[7]);

  a_r9_set_master: assert property (@(posedge clk) disable iff (!rst_n)
    ((ei || reti) && !di && !(ack && irq)) |=> rd_data[7]);

  a_r9_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> !rd_data[7]);

  a_r3_tick0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick[0] && rd_data[7] && rd_data[0] && !wr_en && !di && !ack)
      |=> (irq && vec == VW'(2)));
endmodule

bind prio_vic prio_vic_chk #(.VW(VW)) u_chk (.*);

// File: tb/prio_vic_bench.sv
`timescale 1ns/1ps
module prio_vic_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] tmr_tick;
  logic       pin_a, pin_b, ei, di, ack, reti, wr_en;
  logic [7:0] wr_data, rd_data, vec;
  logic       irq;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  prio_vic u_prio_vic (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .pin_a(pin_a), .pin_b(pin_b),
    .ei(ei), .di(di), .ack(ack), .reti(reti), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .vec(vec)
  );

  // {mask[7:0], ticks[2:0], irq, vec[7:0]}
  localparam logic [19:0] VT [8] = '{
    {8'hBF, 3'b111, 1'b1, 8'd2},   // R7 all timers, source 0 wins
    {8'hBF, 3'b110, 1'b1, 8'd6},   // R7 source 2 wins
    {8'hBF, 3'b100, 1'b1, 8'd12},  // R7 source 5 alone
    {8'hBE, 3'b111, 1'b1, 8'd6},   // R6 source 0 disabled, skipped
    {8'h3F, 3'b111, 1'b0, 8'd0},   // R6 master off hides all
    {8'hA0, 3'b111, 1'b1, 8'd12},  // R6 only source 5 enabled
    {8'h80, 3'b111, 1'b0, 8'd0},   // R6 no enables
    {8'hBF, 3'b000, 1'b0, 8'd0}    // R3 nothing pending
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [2:0] t);
    tmr_tick = t;
    @(negedge clk);
    tmr_tick = 3'b000;
  endtask

  task automatic s_ack();  ack = 1'b1;  @(negedge clk); ack = 1'b0;  endtask
  task automatic s_ei();   ei = 1'b1;   @(negedge clk); ei = 1'b0;   endtask
  task automatic s_di();   di = 1'b1;   @(negedge clk); di = 1'b0;   endtask
  task automatic s_reti(); reti = 1'b1; @(negedge clk); reti = 1'b0; endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      wr(8'hBF);
      if (irq) s_ack();
    end
    wr(8'h00);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tmr_tick = 3'b000; pin_a = 1'b1; pin_b = 1'b1;
    ei = 1'b0; di = 1'b0; ack = 1'b0; reti = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 vec", vec, 8'd0);

    for (int i = 0; i < 8; i++) begin
      wr(VT[i][19:12]);
      tick(VT[i][11:9]);
      chk($sformatf("R7 vector %0d irq", i), {7'd0, irq}, {7'd0, VT[i][8]});
      chk($sformatf("R7 vector %0d vec", i), vec, VT[i][7:0]);
      drain();
    end

    wr(8'hFF);
    chk("R2 bit6 ignored", rd_data, 8'hBF);
    wr(8'h15);
    chk("R2 readback", rd_data, 8'h15);
    wr(8'h00);

    tick(3'b100);
    chk("R3 masked no irq", {7'd0, irq}, 8'd0);
    wr(8'hA0);
    chk("R3 pending kept", vec, 8'd12);
    drain();

    wr(8'h9A);
    pin_a = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 pin_a fall vec", vec, 8'd4);
    s_ack();
    chk("R8 ack drops irq", {7'd0, irq}, 8'd0);
    chk("R8 ack clears master", rd_data, 8'h1A);
    s_reti();
    chk("R9 reti sets master", rd_data, 8'h9A);
    pin_a = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 pin_a rise vec", vec, 8'd10);
    s_ack(); s_ei();
    pin_b = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 pin_b fall vec", vec, 8'd8);
    s_ack(); s_ei();
    pin_b = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 pin_b rise none", {7'd0, irq}, 8'd0);
    drain();

    wr(8'hBF);
    pin_a = 1'b0; @(negedge clk); pin_a = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 one-clock glitch ignored", {7'd0, irq}, 8'd0);
    wr(8'h82);
    pin_a = 1'b0; repeat (2) @(negedge clk); pin_a = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 two-clock pulse accepted", vec, 8'd4);
    drain();

    wr(8'hBF);
    tick(3'b111);
    s_ack();
    s_ei();
    chk("R8 only served source cleared", vec, 8'd6);
    drain();
    wr(8'h80);
    s_ack();
    chk("R8 ack without irq no effect", rd_data, 8'h80);
    wr(8'h00);

    wr(8'hBF);
    s_di();
    chk("R9 di clears", rd_data, 8'h3F);
    s_ei();
    chk("R9 ei sets", rd_data, 8'hBF);
    ei = 1'b1; di = 1'b1; @(negedge clk); ei = 1'b0; di = 1'b0;
    chk("R9 di beats ei", rd_data, 8'h3F);
    ei = 1'b1; wr(8'h3F); ei = 1'b0;
    chk("R9 strobe beats write", rd_data, 8'hBF);
    tick(3'b001);
    reti = 1'b1; ack = 1'b1; @(negedge clk); reti = 1'b0; ack = 1'b0;
    chk("R9 ack beats reti", rd_data, 8'h3F);
    wr(8'h00);

    wr(8'hBF);
    tick(3'b001);
    chk("R10 source 0 presented", vec, 8'd2);
    ack = 1'b1; tmr_tick = 3'b010;
    @(negedge clk);
    ack = 1'b0; tmr_tick = 3'b000;
    s_ei();
    chk("R10 colliding event kept", vec, 8'd6);
    drain();

    finish_run();
  end
endmodule